// File: doc/BRIEF.md
# Segment Table Address Translator

The translator turns a virtual address into a physical address by segment relocation. The top bits of each virtual address select one of a small set of segments. The remaining bits are an offset within that segment. Each segment has one table entry, which holds a base address, a limit and a valid flag. A lookup that passes its checks returns base plus offset. A lookup that fails returns a protection fault with a cause code, and its physical address is forced to zero so that no memory access can follow from it.

The table sits in on-chip registers. A single write port loads one whole entry per clock, so a context switch reloads all eight segments in eight cycles. A lookup takes the entry's state as it stands in the lookup's own cycle and returns its response one cycle later. A write therefore becomes visible to the lookup in the next cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, and `rsp_vld`, `rsp_fault`, `rsp_cause` and `rsp_paddr` are all zero.
- R2: With the defaults, bits 31:29 of `req_addr` give the segment number and bits 28:0 give the offset. A lookup that passes its checks returns `rsp_paddr` = entry base + offset, modulo 2^32, with `rsp_fault`=0 and `rsp_cause`=2'b00.
- R3: A lookup on a valid entry whose offset is greater than or equal to the entry limit faults with `rsp_cause`=2'b10 and `rsp_paddr`=0. A limit of 0 makes every offset fault.
- R4: A lookup on an entry whose valid flag is clear faults with `rsp_cause`=2'b01 and `rsp_paddr`=0, whatever its limit. The invalid cause takes priority over the limit cause.
- R5: `rsp_vld` is `req_vld` delayed by exactly one cycle. While `rsp_vld` is 0, `rsp_fault`, `rsp_cause` and `rsp_paddr` are 0.
- R6: A configuration write in cycle N does not affect a lookup issued in cycle N, which sees the old entry. Lookups issued from cycle N+1 onward see the new entry.
- R7: A configuration write changes only the entry named by `cfg_idx`. All other entries keep their contents.
- R8: One write loads base, limit and valid together. Writing `cfg_valid`=0 disables a segment that was valid before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | SEG_W | Entry to write |
| cfg_base | input | PA_W | Base address to load |
| cfg_limit | input | ADDR_W-SEG_W | Segment length in bytes |
| cfg_valid | input | 1 | Valid flag to load |
| req_vld | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Virtual address |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 2 | 00 none, 01 invalid segment, 10 over limit |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 3 segment bits and a 32-bit physical address. With these values all eight entries are small enough to sweep in full. The offset field reaches 2^29-1, so the bench can probe the limit boundary at limit-1 and at limit, including the largest limit. A base near the top of the 32-bit space shows the modulo wrap of the sum. Writes and lookups on the same entry in the same cycle show the one-cycle visibility rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_LIMIT   = 2'b10
  } cause_e;

  // Invalid entry outranks an over-limit offset
  function automatic cause_e pick_cause(input logic entry_ok, input logic over);
    if (!entry_ok)  return CAUSE_INVALID;
    else if (over)  return CAUSE_LIMIT;
    else            return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 29,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_valid,
  input  logic [SEG_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_limit
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  valid_q;
  logic [NSEG-1:0]  ent_sel;

  for (genvar g = 0; g < NSEG; g++) begin : g_sel
    assign ent_sel[g] = wr_en && (wr_idx == SEG_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSEG; i++) begin
        if (ent_sel[i]) begin
          base_q[i]  <= wr_base;
          limit_q[i] <= wr_limit;
          valid_q[i] <= wr_valid;
        end
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 29,
  parameter int PA_W  = 32
) (
  input  logic             ent_valid,
  input  logic [PA_W-1:0]  ent_base,
  input  logic [OFF_W-1:0] ent_limit,
  input  logic [OFF_W-1:0] off,
  output logic             over,
  output cause_e           cause,
  output logic [PA_W-1:0]  paddr
);
  function automatic logic beyond(input logic [OFF_W-1:0] o, input logic [OFF_W-1:0] lim);
    return !(o < lim);
  endfunction

  function automatic logic [PA_W-1:0] relocate(input logic [PA_W-1:0] b, input logic [OFF_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  assign over  = beyond(off, ent_limit);
  assign cause = pick_cause(ent_valid, over);
  assign paddr = (cause == CAUSE_NONE) ? relocate(ent_base, off) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 3,
  parameter int PA_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SEG_W-1:0]        cfg_idx,
  input  logic [PA_W-1:0]         cfg_base,
  input  logic [ADDR_W-SEG_W-1:0] cfg_limit,
  input  logic                    cfg_valid,
  input  logic                    req_vld,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_vld,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0] lk_seg;
  logic [OFF_W-1:0] lk_off;
  logic             lk_valid;
  logic [PA_W-1:0]  lk_base;
  logic [OFF_W-1:0] lk_limit;
  logic             lk_over;
  cause_e           lk_cause;
  logic [PA_W-1:0]  lk_paddr;

  assign lk_seg = req_addr[ADDR_W-1 -: SEG_W];
  assign lk_off = req_addr[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_valid(cfg_valid),
    .rd_idx(lk_seg), .rd_valid(lk_valid), .rd_base(lk_base), .rd_limit(lk_limit)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .ent_valid(lk_valid), .ent_base(lk_base), .ent_limit(lk_limit),
    .off(lk_off), .over(lk_over), .cause(lk_cause), .paddr(lk_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_paddr <= lk_paddr;
        rsp_fault <= (lk_cause != CAUSE_NONE);
        rsp_cause <= lk_cause;
      end else begin
        rsp_paddr <= '0;
        rsp_fault <= 1'b0;
        rsp_cause <= CAUSE_NONE;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic            lk_valid,
  input logic            lk_over,
  input logic            rsp_vld,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause
);
  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!rsp_fault && rsp_cause == 2'b00 && rsp_paddr == '0));
  p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && rsp_cause != 2'b00));
  p_invalid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !lk_valid) |=> (rsp_fault && rsp_cause == CAUSE_INVALID));
  p_limit_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && lk_valid && lk_over) |=> (rsp_fault && rsp_cause == CAUSE_LIMIT));
  p_pass_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && lk_valid && !lk_over) |=> (!rsp_fault && rsp_cause == CAUSE_NONE));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
  .lk_valid(lk_valid), .lk_over(lk_over),
  .rsp_vld(rsp_vld), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [28:0] cfg_limit = '0;
  logic        cfg_valid = 1'b0;
  logic        req_vld = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_vld;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  always #2.5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .req_vld(req_vld), .req_addr(req_addr), .rsp_vld(rsp_vld),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  int errors = 0;
  int checks = 0;

  // reference model state
  longint unsigned m_base [8];
  longint unsigned m_lim  [8];
  bit              m_val  [8];

  bit          e_vld = 0;
  logic [31:0] e_pa = '0;
  bit          e_fault = 0;
  logic [1:0]  e_cause = '0;
  string       e_tag = "R5";

  task automatic chk(input string tag, input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "rsp_vld", rsp_vld, e_vld);
    chk(e_tag, "rsp_fault", rsp_fault, e_fault);
    chk(e_tag, "rsp_cause", rsp_cause, e_cause);
    chk(e_tag, "rsp_paddr", rsp_paddr, e_pa);
  endtask

  task automatic cycle(input bit rv, input logic [31:0] ra,
                       input bit we, input int wi, input logic [31:0] wb,
                       input logic [28:0] wl, input bit wv, input string tag);
    int s;
    longint unsigned o;
    @(negedge clk);
    compare();
    req_vld = rv; req_addr = ra;
    cfg_we = we; cfg_idx = 3'(wi); cfg_base = wb; cfg_limit = wl; cfg_valid = wv;
    s = int'(ra >> 29);
    o = longint'(ra & 32'h1FFF_FFFF);
    e_vld = rv; e_fault = 0; e_cause = 2'b00; e_pa = '0;
    if (rv) begin
      if (!m_val[s]) begin e_fault = 1; e_cause = 2'b01; end
      else if (o >= m_lim[s]) begin e_fault = 1; e_cause = 2'b10; end
      else e_pa = 32'((m_base[s] + o) % 64'h1_0000_0000);
    end
    if (tag != "") e_tag = tag;
    else if (!rv) e_tag = "R5";
    else if (e_cause == 2'b01) e_tag = "R4";
    else if (e_cause == 2'b10) e_tag = "R3";
    else e_tag = "R2";
    if (we) begin
      m_base[wi] = longint'(wb); m_lim[wi] = longint'(wl); m_val[wi] = wv;
    end
  endtask

  function automatic logic [31:0] va(input int s, input longint unsigned o);
    return {3'(s), 29'(o)};
  endfunction

  task automatic look(input int s, input longint unsigned o, input string tag);
    cycle(1, va(s, o), 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int i, input logic [31:0] b, input logic [28:0] l, input bit v);
    cycle(0, 0, 1, i, b, l, v, "");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lim[i] = 0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    chk("R1", "rsp_vld", rsp_vld, 0);
    chk("R1", "rsp_fault", rsp_fault, 0);
    chk("R1", "rsp_cause", rsp_cause, 0);
    chk("R1", "rsp_paddr", rsp_paddr, 0);
    rst_n = 1'b1;
    // R1: all entries invalid after reset
    for (int s = 0; s < 8; s++) look(s, 0, "R1");

    // R2/R7: load the table
    wr(0, 32'h0001_0000, 29'h1000, 1);
    wr(1, 32'h0800_0000, 29'h1FFF_FFFF, 1);
    wr(2, 32'h0040_0000, 29'h0100, 1);
    wr(3, 32'h1234_0000, 29'h0, 1);
    wr(4, 32'hFFFF_F000, 29'h4000, 1);
    wr(5, 32'h0200_0000, 29'h0800, 0);
    wr(6, 32'h3000_0000, 29'h0001, 1);
    wr(7, 32'h7000_0000, 29'h0010_0000, 1);

    look(0, 0, "");             // R2 base
    look(0, 29'hFFF, "");       // R2 limit-1
    look(0, 29'h1000, "");      // R3 at limit
    look(1, 29'h1FFF_FFFE, ""); // R2 largest legal offset
    look(1, 29'h1FFF_FFFF, ""); // R3 max offset
    look(3, 0, "");             // R3 limit 0
    look(4, 29'h2000, "");      // R2 wrap modulo 2^32
    look(5, 0, "");             // R4 invalid despite limit
    look(6, 0, "");
    look(6, 1, "");
    look(7, 29'h5_4321, "");

    // R5: idle gaps between requests
    cycle(0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R5");
    look(2, 29'h80, "R5");
    cycle(0, 0, 0, 0, 0, 0, 0, "R5");

    // R6: same-cycle write uses old entry, next cycle new
    cycle(1, va(2, 29'h10), 1, 2, 32'h0900_0000, 29'h20, 1, "R6");
    look(2, 29'h10, "R6");
    look(2, 29'h20, "R6");
    // R7: neighbours unchanged
    look(0, 29'h10, "R7");
    look(1, 29'h10, "R7");
    look(3, 0, "R7");
    // R8: disable a valid segment
    wr(7, 32'h7000_0000, 29'h0010_0000, 0);
    look(7, 29'h10, "R8");
    // R6: write segment 5 valid, look up same cycle then after
    cycle(1, va(5, 4), 1, 5, 32'h0000_0100, 29'h8, 1, "R6");
    look(5, 4, "R6");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      bit we = ($urandom % 5) == 0;
      cycle(($urandom % 4) != 0, $urandom, we, int'($urandom % 8),
            $urandom, 29'($urandom % 32'h0000_4000), ($urandom % 4) != 0, "");
    end
    cycle(0, 0, 0, 0, 0, 0, 0, "");
    cycle(0, 0, 0, 0, 0, 0, 0, "");
    finish_run();
  end
endmodule